// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Controller

This block arbitrates the interrupt requests of a two-channel serial controller and turns the winner into an 8-bit vector for a vectored-interrupt CPU. Each channel has four request sources: special receive condition, receive character available, transmit buffer empty and external/status change. The UART shifters and the modem pin logic sit outside the block. They reach it as one-cycle strobes. A pending latch holds each request until that source's own clear path releases it.

Arbitration goes first by channel and then by source. The block drives an active-low interrupt request while it has an eligible request and its daisy-chain enable input is high. On an acknowledge, it presents the vector and marks the winning level as in service. That level, and every level below it, stays blocked until a return-from-interrupt strobe. Higher levels can still nest. The vector's low byte comes from a base register held in channel B. When the status-affects-vector mode is on, bits 3..1 of the vector are replaced by a code for the winning condition, so the CPU can branch to one of eight handlers through its 16-bit table.

Top module: `serial_irq_vectorer`

## Requirements
- R1: After reset, `int_n` is high, `ieo` follows `iei`, `vec_oe` is low and `status_vec` is 0x00. All modes are off and nothing is pending or in service.
- R2: Any eligible channel A request wins over every channel B request, whatever the source types.
- R3: Within a channel, sources rank in this order, highest first: special receive, receive, transmit, external/status.
- R4: Mode register (address 1) bits 4:3 = 1x select interrupt on every received character. Each `rx_char` strobe raises receive pending, and a `rx_read` strobe of that channel clears it.
- R5: Mode bits 4:3 = 01 select interrupt on the first character only. A character raises receive pending once. Later characters raise nothing until command 0x20 is written to that channel's command register (address 0).
- R6: With transmit enable set (mode bit 1), a `tx_empty` strobe raises transmit pending. Only command 0x28 at address 0 of that channel clears it. A data read or a different command leaves it pending.
- R7: With external enable set (mode bit 0), an `ext_chg` strobe raises external/status pending. Command 0x10 at address 0 of that channel clears it, and command 0x28 does not.
- R8: Channel B address 2 holds the vector base. When channel B mode bit 2 is clear, the vector is the base unchanged. When the bit is set and a request is eligible, vector bits 3..1 carry the winner's code and the other bits keep the base. The codes are: B transmit 000, B external 001, B receive 010, B special 011, A transmit 100, A external 101, A receive 110, A special 111.
- R9: `status_vec` always shows the vector for the current winner, without any acknowledge. `ack_vec` carries the same value, and `vec_oe` is high during `ack` while `iei` is high and a request is eligible.
- R10: An acknowledge marks the winning level in service. That level and every lower level are blocked and hold `ieo` low. A higher level can still request. Each `reti` strobe releases the highest level in service.
- R11: With `iei` low, `int_n` is high, `ieo` is low and an acknowledge changes nothing.
- R12: A source whose enable is off (transmit and external by their mode bits, receive by mode bits 4:3 = 00) raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_b | input | 1 | Write target channel: 0 = A, 1 = B |
| wr_addr | input | 2 | 0 command, 1 mode, 2 vector base (channel B only) |
| wr_data | input | 8 | Write data |
| rx_char | input | 2 | Character received strobe, bit 0 = A, bit 1 = B |
| rx_err | input | 2 | Special receive condition strobe |
| rx_read | input | 2 | Data register read strobe |
| tx_empty | input | 2 | Transmit buffer became empty strobe |
| ext_chg | input | 2 | Modem/status line transition strobe |
| ack | input | 1 | Interrupt acknowledge cycle |
| reti | input | 1 | Return-from-interrupt indication |
| iei | input | 1 | Daisy-chain enable in |
| ieo | output | 1 | Daisy-chain enable out |
| int_n | output | 1 | Interrupt request, active low |
| ack_vec | output | 8 | Vector driven during acknowledge |
| vec_oe | output | 1 | Vector output enable |
| status_vec | output | 8 | Readable modified vector |

## Verification
The ranking tests raise several sources at once and then remove them one at a time. The expected vector changes at each step only if the source order and the channel order are both correct. A low-ranked A source held against a high-ranked B source tells channel priority apart from source priority. The clear tests send each source the clear paths of the other sources, which shows that each latch answers only to its own release. The nesting test acknowledges a low level, raises a higher one, and then issues two returns, which shows that each return releases the top in-service level and no other.

// File: rtl/serial_irq_vectorer.sv
module serial_irq_vectorer #(
  parameter logic [7:0] CMD_TX_RST  = 8'h28,
  parameter logic [7:0] CMD_EXT_RST = 8'h10,
  parameter logic [7:0] CMD_REARM   = 8'h20,
  parameter logic [7:0] CMD_ERR_RST = 8'h30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_b,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rx_char,
  input  logic [1:0] rx_err,
  input  logic [1:0] rx_read,
  input  logic [1:0] tx_empty,
  input  logic [1:0] ext_chg,
  input  logic       ack,
  input  logic       reti,
  input  logic       iei,
  output logic       ieo,
  output logic       int_n,
  output logic [7:0] ack_vec,
  output logic       vec_oe,
  output logic [7:0] status_vec
);
  localparam int NLVL = 8;

  logic [7:0] vbase;
  logic       sav;
  logic [1:0] ext_en, tx_en, armed;
  logic [1:0] rx_mode [2];
  logic [NLVL-1:0] pend, ius, mask, req;
  logic       win_vld;
  logic [2:0] win, top;
  logic       top_vld;
  logic [7:0] vec;

  function automatic logic [2:0] vcode(input logic [2:0] lvl);
    logic [1:0] s;
    case (lvl[1:0])
      2'd0:    s = 2'b11;
      2'd1:    s = 2'b10;
      2'd2:    s = 2'b00;
      default: s = 2'b01;
    endcase
    return {~lvl[2], s};
  endfunction

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      mask[4*c]   = rx_mode[c] != 2'b00;
      mask[4*c+1] = rx_mode[c] != 2'b00;
      mask[4*c+2] = tx_en[c];
      mask[4*c+3] = ext_en[c];
    end
  end
  assign req = pend & mask;

  always_comb begin
    logic blk;
    blk = 1'b0;
    win_vld = 1'b0;
    win = '0;
    top_vld = 1'b0;
    top = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (!top_vld && ius[i]) begin
        top_vld = 1'b1;
        top = 3'(i);
      end
      blk = blk | ius[i];
      if (!blk && !win_vld && req[i]) begin
        win_vld = 1'b1;
        win = 3'(i);
      end
    end
  end

  assign vec        = (sav && win_vld) ? {vbase[7:4], vcode(win), vbase[0]} : vbase;
  assign status_vec = vec;
  assign ack_vec    = vec;
  assign vec_oe     = ack && iei && win_vld;
  assign int_n      = !(iei && win_vld);
  assign ieo        = iei && !(|req) && !(|ius);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vbase   <= '0;
      sav     <= 1'b0;
      ext_en  <= '0;
      tx_en   <= '0;
      armed   <= '1;
      rx_mode <= '{2'b00, 2'b00};
      pend    <= '0;
      ius     <= '0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        logic sel, cmd;
        sel = wr_en && (wr_b == c[0]);
        cmd = sel && wr_addr == 2'd0;
        if (sel && wr_addr == 2'd1) begin
          ext_en[c]  <= wr_data[0];
          tx_en[c]   <= wr_data[1];
          rx_mode[c] <= wr_data[4:3];
          if (c == 1) sav <= wr_data[2];
        end
        if (c == 1 && sel && wr_addr == 2'd2) vbase <= wr_data;

        if (rx_char[c]) begin
          if (rx_mode[c][1]) pend[4*c+1] <= 1'b1;
          else if (rx_mode[c] == 2'b01 && armed[c]) begin
            pend[4*c+1] <= 1'b1;
            armed[c]    <= 1'b0;
          end
        end
        if (rx_read[c]) pend[4*c+1] <= 1'b0;
        if (cmd && wr_data == CMD_REARM) armed[c] <= 1'b1;

        if (rx_err[c] && rx_mode[c] != 2'b00) pend[4*c] <= 1'b1;
        if (cmd && wr_data == CMD_ERR_RST) pend[4*c] <= 1'b0;

        if (tx_empty[c] && tx_en[c]) pend[4*c+2] <= 1'b1;
        if (cmd && wr_data == CMD_TX_RST) pend[4*c+2] <= 1'b0;

        if (ext_chg[c] && ext_en[c]) pend[4*c+3] <= 1'b1;
        if (cmd && wr_data == CMD_EXT_RST) pend[4*c+3] <= 1'b0;
      end

      if (reti && top_vld) ius[top] <= 1'b0;
      if (ack && iei && win_vld) ius[win] <= 1'b1;
    end
  end

  assert_ius_set_by_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ius & ~$past(ius))) |-> $past(ack));

  assert_ius_clear_by_reti_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~ius & $past(ius))) |-> $past(reti));

  assert_tx_clear_cmd_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend[2]) |-> $past(wr_en && !wr_b && wr_addr == 2'd0 && wr_data == CMD_TX_RST));

  assert_iei_low_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !iei |-> (int_n && !ieo && !vec_oe));

  assert_in_service_holds_ieo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|ius) |-> !ieo);
endmodule

// File: tb/serial_irq_vectorer_bench.sv
module serial_irq_vectorer_bench;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_b = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] rx_char = 0, rx_err = 0, rx_read = 0, tx_empty = 0, ext_chg = 0;
  logic ack = 0, reti = 0, iei = 1;
  logic ieo, int_n, vec_oe;
  logic [7:0] ack_vec, status_vec;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_irq_vectorer u_serial_irq_vectorer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_b(wr_b), .wr_addr(wr_addr),
    .wr_data(wr_data), .rx_char(rx_char), .rx_err(rx_err), .rx_read(rx_read),
    .tx_empty(tx_empty), .ext_chg(ext_chg), .ack(ack), .reti(reti), .iei(iei),
    .ieo(ieo), .int_n(int_n), .ack_vec(ack_vec), .vec_oe(vec_oe),
    .status_vec(status_vec));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_vec(input string req, input logic [7:0] exp);
    chk(int_n == 0 && status_vec == exp, req, {int_n, status_vec}, exp);
  endtask

  task automatic chk_idle(input string req);
    chk(int_n == 1, req, int_n, 1);
  endtask

  task automatic wr(input logic b, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_b = b; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  // kind: 0 rx_char, 1 rx_err, 2 rx_read, 3 tx_empty, 4 ext_chg
  task automatic pulse(input int kind, input logic [1:0] m);
    @(negedge clk);
    case (kind)
      0: rx_char = m;
      1: rx_err = m;
      2: rx_read = m;
      3: tx_empty = m;
      default: ext_chg = m;
    endcase
    @(negedge clk);
    rx_char = 0; rx_err = 0; rx_read = 0; tx_empty = 0; ext_chg = 0;
  endtask

  task automatic do_reti();
    @(negedge clk); reti = 1;
    @(negedge clk); reti = 0;
  endtask

  task automatic t_reset();
    chk(int_n == 1 && ieo == 1 && vec_oe == 0 && status_vec == 0, "R1",
        {int_n, ieo, vec_oe, status_vec}, 12'h600);
  endtask

  task automatic t_disabled();
    pulse(3, 2'b01); pulse(4, 2'b01); pulse(0, 2'b01); pulse(1, 2'b01);
    chk(int_n == 1 && ieo == 1, "R12", {int_n, ieo}, 2'b11);
  endtask

  task automatic t_vector_modes();
    wr(1, 2, 8'hA1);
    wr(0, 1, 8'h13);
    wr(1, 1, 8'h13);
    pulse(4, 2'b10);
    chk_vec("R8 plain base", 8'hA1);
    wr(1, 1, 8'h17);
    chk_vec("R8 modified B ext", 8'hA3);
    chk(status_vec == ack_vec, "R9 status equals ack_vec", ack_vec, status_vec);
    wr(1, 0, 8'h10);
    chk_idle("R7 ext B cleared");
  endtask

  task automatic t_rank_within();
    pulse(4, 2'b01); pulse(3, 2'b01); pulse(0, 2'b01); pulse(1, 2'b01);
    chk_vec("R3 special top", 8'hAF);
    wr(0, 0, 8'h30);
    chk_vec("R3 receive next", 8'hAD);
    pulse(2, 2'b01);
    chk_vec("R3 transmit next", 8'hA9);
    wr(0, 0, 8'h28);
    chk_vec("R3 external last", 8'hAB);
    wr(0, 0, 8'h10);
    chk_idle("R3 all cleared");
  endtask

  task automatic t_rank_channel();
    pulse(0, 2'b10);
    chk_vec("R2 B receive alone", 8'hA5);
    pulse(4, 2'b01);
    chk_vec("R2 A ext beats B receive", 8'hAB);
    wr(0, 0, 8'h10);
    chk_vec("R2 B receive returns", 8'hA5);
    pulse(2, 2'b10);
    chk_idle("R2 cleared");
  endtask

  task automatic t_rx_all();
    pulse(0, 2'b01);
    chk_vec("R4 first char", 8'hAD);
    pulse(2, 2'b01);
    chk_idle("R4 read clears");
    pulse(0, 2'b01);
    chk_vec("R4 second char", 8'hAD);
    pulse(2, 2'b01);
    chk_idle("R4 read clears again");
  endtask

  task automatic t_rx_first();
    wr(0, 1, 8'h0B);
    pulse(0, 2'b01);
    chk_vec("R5 first char raises", 8'hAD);
    pulse(2, 2'b01);
    pulse(0, 2'b01);
    chk_idle("R5 later char silent");
    wr(0, 0, 8'h20);
    chk_idle("R5 rearm alone silent");
    pulse(0, 2'b01);
    chk_vec("R5 after rearm", 8'hAD);
    pulse(2, 2'b01);
    wr(0, 1, 8'h13);
  endtask

  task automatic t_tx();
    pulse(3, 2'b01);
    chk_vec("R6 tx raised", 8'hA9);
    pulse(2, 2'b01);
    chk_vec("R6 read ignored", 8'hA9);
    wr(0, 0, 8'h10);
    chk_vec("R6 ext reset ignored", 8'hA9);
    wr(1, 0, 8'h28);
    chk_vec("R6 other channel ignored", 8'hA9);
    wr(0, 0, 8'h28);
    chk_idle("R6 tx reset clears");
  endtask

  task automatic t_ext();
    pulse(4, 2'b10);
    chk_vec("R7 ext raised", 8'hA3);
    wr(1, 0, 8'h28);
    chk_vec("R7 tx reset ignored", 8'hA3);
    wr(1, 0, 8'h10);
    chk_idle("R7 ext reset clears");
  endtask

  task automatic t_nesting();
    pulse(3, 2'b10);
    chk_vec("R10 B tx requests", 8'hA1);
    @(negedge clk); ack = 1;
    #1 chk(vec_oe == 1 && ack_vec == 8'hA1, "R9 ack vector", {vec_oe, ack_vec}, 9'h1A1);
    @(negedge clk); ack = 0;
    chk(int_n == 1 && ieo == 0, "R10 in service blocks", {int_n, ieo}, 2'b10);
    pulse(0, 2'b01);
    chk_vec("R10 higher nests", 8'hAD);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    chk_idle("R10 A rx in service");
    do_reti();
    chk_vec("R10 reti releases top", 8'hAD);
    pulse(2, 2'b01);
    chk(int_n == 1 && ieo == 0, "R10 B still in service", {int_n, ieo}, 2'b10);
    do_reti();
    chk_vec("R10 second reti releases B", 8'hA1);
    wr(1, 0, 8'h28);
    chk(int_n == 1 && ieo == 1, "R10 all released", {int_n, ieo}, 2'b11);
  endtask

  task automatic t_chain();
    pulse(4, 2'b01);
    @(negedge clk); iei = 0;
    #1 chk(int_n == 1 && ieo == 0, "R11 iei low", {int_n, ieo}, 2'b10);
    ack = 1;
    #1 chk(vec_oe == 0, "R11 no vector", vec_oe, 0);
    @(negedge clk); ack = 0; iei = 1;
    #1 chk_vec("R11 ack ignored", 8'hAB);
    chk(ieo == 0, "R11 pending holds ieo", ieo, 0);
    wr(0, 0, 8'h10);
    chk(int_n == 1 && ieo == 1, "R11 cleared", {int_n, ieo}, 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_vector_modes();
    t_rank_within();
    t_rank_channel();
    t_rx_all();
    t_rx_first();
    t_tx();
    t_ext();
    t_nesting();
    t_chain();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule